// File: doc/BRIEF.md
# Two-Operand Instruction Operand Decoder

This block parses the byte stream of a 16-bit two-operand instruction format, taking one byte per accepted cycle. Each instruction starts with an operation byte and an addressing byte. Zero, one or two displacement bytes may follow, and the addressing byte decides how many. When the last byte of an instruction has been accepted, the block presents a descriptor for one cycle.

The descriptor carries:
- the operation bits and the direction and width flags;
- a decoded selector for the register operand;
- the second operand. This is either a register selector or a 16-bit effective address. The address is formed from the supplied base, pointer and index register values plus the displacement.

A front-end uses this block to turn raw instruction bytes into operand routing for an execution stage. Immediate data, segments, prefixes and the memory access itself are handled elsewhere.

Top module: `opdec_top`

## Requirements
- R1: In the operation byte, bits 7:2 appear on `out_op`, bit 1 appears on `out_dir` and bit 0 appears on `out_wide`. `out_dir` = 1 means the register field names the destination. `out_dir` = 0 means it names the source.
- R2: In the addressing byte, bits 7:6 are the mode, bits 5:3 are the register field and bits 2:0 are the r/m field. The instruction length depends on these fields:
  - 2 bytes for mode 11, and for mode 00 with r/m other than 110;
  - 3 bytes for mode 01;
  - 4 bytes for mode 10, and for mode 00 with r/m 110.

  `out_valid` is high for exactly the one cycle after the last byte is accepted, and low at all other times.
- R3: Register selectors are reported as an index and a lane. Lane 00 is the full word, lane 01 is the low byte and lane 10 is the high byte.
  - With the width bit set, index = code and lane = 00.
  - With it clear, codes 0..3 give index = code with lane 01, and codes 4..7 give index = code-4 with lane 10.
- R4: Mode 11 reports `out_rm_is_mem` = 0. The r/m field is decoded into `out_rm_idx`/`out_rm_lane` by the R3 mapping, and `out_ea` = 0.
- R5: Modes 00, 01 and 10 report `out_rm_is_mem` = 1, with rm selector outputs 0. The r/m code selects the base sum:
  - 000 bx+si, 001 bx+di, 010 bp+si, 011 bp+di;
  - 100 si, 101 di, 110 bp, 111 bx.

  In mode 00 nothing is added.
- R6: Mode 01 adds its single displacement byte after sign extension to 16 bits.
- R7: Mode 10 adds a 16-bit displacement sent low byte first.
- R8: Mode 00 with r/m 110 uses no register. The effective address is the next two bytes, low byte first.
- R9: Effective address sums wrap modulo 2^16. The register inputs are taken in the cycle the last byte is accepted.
- R10: `in_ready` is high whenever reset is low. Idle cycles between bytes do not disturb parsing. A new operation byte is accepted in the cycle right after an instruction's last byte.
- R11: Reset drives `out_valid` low and returns parsing to the operation byte, discarding a partly received instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| bx_val | input | 16 | Base register value |
| bp_val | input | 16 | Frame pointer register value |
| si_val | input | 16 | Source index register value |
| di_val | input | 16 | Destination index register value |
| out_valid | output | 1 | Descriptor valid (one cycle) |
| out_op | output | 6 | Operation bits |
| out_dir | output | 1 | 1: register field is destination |
| out_wide | output | 1 | 1: word operation |
| out_reg_idx | output | 3 | Register operand index |
| out_reg_lane | output | 2 | Register operand lane |
| out_rm_is_mem | output | 1 | Second operand is memory |
| out_rm_idx | output | 3 | Second operand register index |
| out_rm_lane | output | 2 | Second operand register lane |
| out_ea | output | 16 | Effective address |

## Verification
The bench uses the default configuration: 8-bit bytes and a 16-bit address. At that size every one of the 256 addressing bytes can be swept, so every mode, register code and r/m form is covered, with both values of the width and direction bits. The sweep runs twice. The first register set gives plain sums. The second uses values near the top of the address space, together with displacement bytes around 0x7F/0x80, so sign extension and modulo-2^16 wrap are both exercised. Idle gaps are inserted between some bytes, and a reset is applied in the middle of an instruction.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 2 * BYTE_W;
    localparam int OP_W    = BYTE_W - 2;
    localparam int FIELD_W = 3;

    typedef enum logic [1:0] {
        PH_OPC   = 2'd0,
        PH_MODRM = 2'd1,
        PH_DLO   = 2'd2,
        PH_DHI   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        LANE_WORD = 2'b00,
        LANE_LO   = 2'b01,
        LANE_HI   = 2'b10
    } lane_e;

    typedef struct packed {
        logic [FIELD_W-1:0] idx;
        lane_e              lane;
    } regsel_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic              dir;
        logic              wide;
        regsel_t           reg_sel;
        logic              rm_mem;
        regsel_t           rm_sel;
        logic [ADDR_W-1:0] ea;
    } desc_t;

    // number of displacement bytes following the addressing byte
    function automatic logic [1:0] disp_len(input logic [1:0] mode,
                                            input logic [FIELD_W-1:0] rm);
        logic [1:0] n;
        case (mode)
            2'b00:   n = (rm == 3'b110) ? 2'd2 : 2'd0;
            2'b01:   n = 2'd1;
            2'b10:   n = 2'd2;
            default: n = 2'd0;
        endcase
        return n;
    endfunction

    function automatic regsel_t map_reg(input logic [FIELD_W-1:0] code,
                                        input logic wide);
        regsel_t r;
        if (wide) begin
            r.idx  = code;
            r.lane = LANE_WORD;
        end else begin
            r.idx  = {1'b0, code[FIELD_W-2:0]};
            r.lane = code[FIELD_W-1] ? LANE_HI : LANE_LO;
        end
        return r;
    endfunction

endpackage

// File: rtl/opdec_parser.sv
module opdec_parser
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [BYTE_W-1:0] cur_op,
    output logic [BYTE_W-1:0] cur_modrm,
    output logic [ADDR_W-1:0] cur_disp,
    output logic              fin
);

    phase_e            phase;
    logic [BYTE_W-1:0] op_q;
    logic [BYTE_W-1:0] modrm_q;
    logic [BYTE_W-1:0] lo_q;
    logic [1:0]        len;

    assign cur_op    = op_q;
    assign cur_modrm = (phase == PH_MODRM) ? in_byte : modrm_q;
    assign len       = disp_len(cur_modrm[7:6], cur_modrm[2:0]);

    always_comb begin
        fin      = 1'b0;
        cur_disp = '0;
        case (phase)
            PH_MODRM: fin = acc && (len == 2'd0);
            PH_DLO: begin
                fin      = acc && (len == 2'd1);
                cur_disp = {{(ADDR_W-BYTE_W){in_byte[BYTE_W-1]}}, in_byte};
            end
            PH_DHI: begin
                fin      = acc;
                cur_disp = {in_byte, lo_q};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_OPC;
            op_q    <= '0;
            modrm_q <= '0;
            lo_q    <= '0;
        end else if (acc) begin
            case (phase)
                PH_OPC: begin
                    op_q  <= in_byte;
                    phase <= PH_MODRM;
                end
                PH_MODRM: begin
                    modrm_q <= in_byte;
                    phase   <= (len == 2'd0) ? PH_OPC : PH_DLO;
                end
                PH_DLO: begin
                    lo_q  <= in_byte;
                    phase <= (len == 2'd1) ? PH_OPC : PH_DHI;
                end
                default: phase <= PH_OPC;
            endcase
        end
    end

    // R2
    dhi_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DHI && $past(phase) != PH_DHI) |-> $past(phase) == PH_DLO);

    // R2
    dlo_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DLO && $past(phase) != PH_DLO) |-> $past(phase) == PH_MODRM);

endmodule

// File: rtl/opdec_ea.sv
module opdec_ea
    import opdec_pkg::*;
(
    input  logic [1:0]         mode,
    input  logic [FIELD_W-1:0] rm,
    input  logic [ADDR_W-1:0]  disp,
    input  logic [ADDR_W-1:0]  bx_val,
    input  logic [ADDR_W-1:0]  bp_val,
    input  logic [ADDR_W-1:0]  si_val,
    input  logic [ADDR_W-1:0]  di_val,
    output logic [ADDR_W-1:0]  ea
);

    logic [ADDR_W-1:0] base_sum;

    always_comb begin
        case (rm)
            3'd0:    base_sum = bx_val + si_val;
            3'd1:    base_sum = bx_val + di_val;
            3'd2:    base_sum = bp_val + si_val;
            3'd3:    base_sum = bp_val + di_val;
            3'd4:    base_sum = si_val;
            3'd5:    base_sum = di_val;
            3'd6:    base_sum = bp_val;
            default: base_sum = bx_val;
        endcase
    end

    always_comb begin
        if (mode == 2'b11)
            ea = '0;
        else if (mode == 2'b00 && rm == 3'b110)
            ea = disp;
        else
            ea = base_sum + disp;
    end

endmodule

// File: rtl/opdec_top.sv
module opdec_top
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] bx_val,
    input  logic [ADDR_W-1:0] bp_val,
    input  logic [ADDR_W-1:0] si_val,
    input  logic [ADDR_W-1:0] di_val,
    output logic              out_valid,
    output logic [OP_W-1:0]   out_op,
    output logic              out_dir,
    output logic              out_wide,
    output logic [2:0]        out_reg_idx,
    output logic [1:0]        out_reg_lane,
    output logic              out_rm_is_mem,
    output logic [2:0]        out_rm_idx,
    output logic [1:0]        out_rm_lane,
    output logic [ADDR_W-1:0] out_ea
);

    logic              acc;
    logic              fin;
    logic [BYTE_W-1:0] cur_op;
    logic [BYTE_W-1:0] cur_modrm;
    logic [ADDR_W-1:0] cur_disp;
    logic [ADDR_W-1:0] ea_n;
    desc_t             desc_n;
    desc_t             desc_q;
    logic              valid_q;

    assign in_ready = ~rst;
    assign acc      = in_valid & in_ready;

    opdec_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .in_byte   (in_byte),
        .cur_op    (cur_op),
        .cur_modrm (cur_modrm),
        .cur_disp  (cur_disp),
        .fin       (fin)
    );

    opdec_ea u_ea (
        .mode   (cur_modrm[7:6]),
        .rm     (cur_modrm[2:0]),
        .disp   (cur_disp),
        .bx_val (bx_val),
        .bp_val (bp_val),
        .si_val (si_val),
        .di_val (di_val),
        .ea     (ea_n)
    );

    always_comb begin
        desc_n.op      = cur_op[BYTE_W-1:2];
        desc_n.dir     = cur_op[1];
        desc_n.wide    = cur_op[0];
        desc_n.reg_sel = map_reg(cur_modrm[5:3], cur_op[0]);
        desc_n.rm_mem  = (cur_modrm[7:6] != 2'b11);
        desc_n.rm_sel  = desc_n.rm_mem ? regsel_t'('0)
                                       : map_reg(cur_modrm[2:0], cur_op[0]);
        desc_n.ea      = ea_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            desc_q  <= '0;
        end else begin
            valid_q <= fin;
            if (fin)
                desc_q <= desc_n;
        end
    end

    assign out_valid     = valid_q;
    assign out_op        = desc_q.op;
    assign out_dir       = desc_q.dir;
    assign out_wide      = desc_q.wide;
    assign out_reg_idx   = desc_q.reg_sel.idx;
    assign out_reg_lane  = desc_q.reg_sel.lane;
    assign out_rm_is_mem = desc_q.rm_mem;
    assign out_rm_idx    = desc_q.rm_sel.idx;
    assign out_rm_lane   = desc_q.rm_sel.lane;
    assign out_ea        = desc_q.ea;

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R2
    valid_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R10
    ready_high_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready);

    // R4
    regform_ea_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_rm_is_mem) |-> (out_ea == '0));

    // R3
    wide_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_wide) |-> (out_reg_lane == 2'b00));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/opdec_top_tb.sv
`timescale 1ns/100ps
module opdec_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready;
    logic [15:0] bx_val = '0, bp_val = '0, si_val = '0, di_val = '0;
    logic        out_valid;
    logic [5:0]  out_op;
    logic        out_dir, out_wide;
    logic [2:0]  out_reg_idx;
    logic [1:0]  out_reg_lane;
    logic        out_rm_is_mem;
    logic [2:0]  out_rm_idx;
    logic [1:0]  out_rm_lane;
    logic [15:0] out_ea;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    opdec_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .bx_val(bx_val), .bp_val(bp_val),
        .si_val(si_val), .di_val(di_val), .out_valid(out_valid),
        .out_op(out_op), .out_dir(out_dir), .out_wide(out_wide),
        .out_reg_idx(out_reg_idx), .out_reg_lane(out_reg_lane),
        .out_rm_is_mem(out_rm_is_mem), .out_rm_idx(out_rm_idx),
        .out_rm_lane(out_rm_lane), .out_ea(out_ea)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // drive one byte, sampled after the accepting edge
    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [4:0] exp_sel(input logic [2:0] code, input logic w);
        if (w) return {code, 2'b00};
        if (code < 3'd4) return {code, 2'b01};
        return {code - 3'd4, 2'b10};
    endfunction

    function automatic logic [15:0] exp_base(input logic [2:0] rm);
        case (rm)
            3'd0: return bx_val + si_val;
            3'd1: return bx_val + di_val;
            3'd2: return bp_val + si_val;
            3'd3: return bp_val + di_val;
            3'd4: return si_val;
            3'd5: return di_val;
            3'd6: return bp_val;
            default: return bx_val;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle();
        // R11 reset state
        chk("R11 valid in reset", out_valid, 0);
        chk("R10 ready in reset", in_ready, 0);
        rst = 1'b0;
        idle();
        chk("R11 valid after reset", out_valid, 0);
        chk("R10 ready after reset", in_ready, 1);

        for (int s = 0; s < 2; s++) begin
            if (s == 0) begin
                bx_val = 16'h1234; bp_val = 16'h2000; si_val = 16'h0011; di_val = 16'h0100;
            end else begin
                bx_val = 16'hFFF0; bp_val = 16'hFF00; si_val = 16'h0020; di_val = 16'h8001;
            end
            for (int m = 0; m < 256; m++) begin
                logic [7:0]  opb, mrm, lo, hi;
                logic [1:0]  mode, n;
                logic [2:0]  rm;
                logic [15:0] disp, ea;
                logic        gap;
                string       tag;
                opb  = 8'((m * 37) + (s * 5));
                mrm  = 8'(m);
                lo   = 8'((m * 29) + 8'h7E);
                hi   = 8'(m) ^ 8'hA5;
                mode = mrm[7:6];
                rm   = mrm[2:0];
                gap  = (m % 7) == 3;
                n    = (mode == 2'b01) ? 2'd1 :
                       (mode == 2'b10) ? 2'd2 :
                       (mode == 2'b00 && rm == 3'd6) ? 2'd2 : 2'd0;

                send(opb);
                chk("R2 no valid mid-instr", out_valid, 0);
                if (gap) begin idle(); chk("R10 idle hold", out_valid, 0); end
                send(mrm);
                if (n >= 1) begin
                    chk("R2 no valid before disp", out_valid, 0);
                    if (gap) idle();
                    send(lo);
                end
                if (n == 2) begin
                    chk("R2 no valid before disp hi", out_valid, 0);
                    if (gap) idle();
                    send(hi);
                end

                if (mode == 2'b11) begin disp = 16'h0; tag = "R4"; end
                else if (mode == 2'b01) begin disp = {{8{lo[7]}}, lo}; tag = "R6"; end
                else if (mode == 2'b10) begin disp = {hi, lo}; tag = "R7"; end
                else if (rm == 3'd6) begin disp = {hi, lo}; tag = "R8"; end
                else begin disp = 16'h0; tag = "R5"; end
                if (mode == 2'b11) ea = 16'h0;
                else if (mode == 2'b00 && rm == 3'd6) ea = disp;
                else ea = 16'(exp_base(rm) + disp);
                if (s == 1 && mode != 2'b11 && !(mode == 2'b00 && rm == 3'd6)) tag = "R9";

                chk("R2 valid after last byte", out_valid, 1);
                chk("R1 op", out_op, opb[7:2]);
                chk("R1 dir", out_dir, opb[1]);
                chk("R1 wide", out_wide, opb[0]);
                chk("R3 reg selector", {out_reg_idx, out_reg_lane}, exp_sel(mrm[5:3], opb[0]));
                chk("R4 R5 mem flag", out_rm_is_mem, mode != 2'b11);
                chk("R4 R5 rm selector", {out_rm_idx, out_rm_lane},
                    (mode == 2'b11) ? exp_sel(rm, opb[0]) : 5'd0);
                chk({tag, " effective address"}, out_ea, ea);
                if (gap) begin idle(); chk("R2 single-cycle valid", out_valid, 0); end
            end
        end

        // R11 reset mid-instruction discards partial bytes
        send(8'h01);
        send(8'h80);
        send(8'h55);
        rst = 1'b1;
        idle();
        chk("R11 valid during reset", out_valid, 0);
        rst = 1'b0;
        send(8'h8A);
        send(8'hE3);
        chk("R11 fresh decode valid", out_valid, 1);
        chk("R11 fresh decode op", out_op, 6'h22);
        chk("R11 fresh decode reg", {out_reg_idx, out_reg_lane}, {3'd0, 2'b10});
        chk("R11 fresh decode rm", {out_rm_idx, out_rm_lane}, {3'd3, 2'b01});

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule